// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel Port

This block is an eight-bit general-purpose port for a small processor core. Every bit owns a storage flop that the core loads, and the flop alone decides what happens at the pad. A stored 0 pulls the pad hard to ground. A stored 1 releases the pad: either an internal pull-up holds it high, or, in the open-drain build, nothing does and the board must supply a resistor. A bit therefore works as an input only after a 1 has been stored in it.

The core sees two distinct read values. One is the level present at the pads, gated by the stored value, because a bit that drives low always reads low. The other is the stored byte itself. Arithmetic and logic updates read the stored byte and not the pads, compute, and write the result back. The result shows at the pads on the next cycle. Single bits can be set, cleared, complemented or tested-and-cleared without disturbing the other seven.

Top module: `qbd_port`

## Requirements
- R1: After synchronous active-low reset the stored byte (`rd_latch`) is all ones, `pad_drive_low` is all zeros and, with the pull-up build, `pad_pullup_en` is all ones.
- R2: With `wr_en` high and `op_en` low, `rd_latch` equals `wr_data` from the next cycle. With neither enable high, the stored byte holds its value whatever `wr_data` carries.
- R3: `rd_pin` equals the stored byte ANDed with `pad_in`. A bit holding 1 whose pad is pulled low reads 0 on `rd_pin` and 1 on `rd_latch`. `rd_latch` never depends on `pad_in`.
- R4: `pad_drive_low` is the complement of the stored byte. `pad_pullup_en` equals the stored byte when `HAS_PULLUP` is 1 and is all zeros when it is 0.
- R5: With `op_en` high, the byte codes 0 (AND), 1 (OR) and 2 (XOR) combine the stored byte, never the pads, with `op_operand`, and store the result.
- R6: Code 3 adds one and code 4 subtracts one, both modulo 256. For code 4, `op_flag` is 1 when the new value is nonzero, giving a decrement-and-branch test.
- R7: Codes 5 (set), 6 (clear) and 7 (complement) change only the bit that `bit_sel` names and leave the other bits unchanged.
- R8: Code 8 (test-and-clear) drives `op_flag` with the old value of the selected stored bit in the same cycle and clears that bit. Codes other than 4 and 8 give `op_flag` 0.
- R9: When `op_en` and `wr_en` are both high, the operation result is stored and `wr_data` is ignored.
- R10: Codes 9 to 15 with `op_en` high leave the stored byte unchanged, give `op_flag` 0, and also block a simultaneous write.
- R11: `pin_bit` is the `rd_pin` bit that `bit_sel` names, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Whole-byte store strobe |
| wr_data | input | 8 | Byte to store |
| op_en | input | 1 | Read-modify-write strobe |
| op_code | input | 4 | Operation code, see R5 to R10 |
| op_operand | input | 8 | Second operand for AND, OR, XOR |
| bit_sel | input | 3 | Bit index for bit operations and `pin_bit` |
| pad_in | input | 8 | Level sensed at each pad |
| rd_pin | output | 8 | Pad read value |
| rd_latch | output | 8 | Stored byte |
| pin_bit | output | 1 | Selected pad read bit |
| op_flag | output | 1 | Test result of the current operation |
| pad_drive_low | output | 8 | Pull-down enable per pad |
| pad_pullup_en | output | 8 | Internal pull-up enable per pad |

## Verification
On every cycle the assertions check several rules. A pad that is driven low never reads high and never has its pull-up on. The stored byte holds when no update mask is set. A lone write lands in the next cycle. An AND that collides with a write wins. An increment from all ones wraps to zero. A bit operation touches exactly one bit. The bench scenarios cover the rest: the reset value, the exact arithmetic and bit results on a quiet pad bus, the value returned by test-and-clear, the codes that do nothing, and the difference between the open-drain and pull-up builds.

// File: rtl/qbd_port_pkg.sv
// Package: shared operation codes and sizing for the quasi-bidirectional port.
// Assumes: the op code field is four bits wide; codes 9..15 are reserved.
package qbd_port_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_SETB = 4'd5,
        OP_CLRB = 4'd6,
        OP_CPLB = 4'd7,
        OP_TCLR = 4'd8
    } port_op_e;

endpackage

// File: rtl/qbd_port_alu.sv
// Module: combinational read-modify-write unit.
// Computes the new stored value, a per-bit update mask and the test flag
// from the current stored byte (never the pads). Reserved codes yield an
// empty mask. Assumes W is a power of two so bit_sel covers every bit.
module qbd_port_alu
    import qbd_port_pkg::*;
#(
    parameter int W    = 8,
    parameter int IDXW = $clog2(W)
) (
    input  logic             rst_n,
    input  logic             op_en,
    input  logic [OP_W-1:0]  op_code,
    input  logic [W-1:0]     latch_q,
    input  logic [W-1:0]     op_operand,
    input  logic [IDXW-1:0]  bit_sel,
    output logic [W-1:0]     upd_mask,
    output logic [W-1:0]     upd_data,
    output logic             op_flag
);

    localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ALL_1 = {W{1'b1}};

    logic [W-1:0] sel_mask;
    port_op_e     code;

    assign sel_mask = ONE << bit_sel;
    assign code     = port_op_e'(op_code);

    // Select the operation result, the bits it may change and its flag.
    always_comb begin
        upd_mask = '0;
        upd_data = latch_q;
        op_flag  = 1'b0;
        if (op_en) begin
            case (code)
                OP_AND:  begin upd_mask = ALL_1; upd_data = latch_q & op_operand; end
                OP_OR:   begin upd_mask = ALL_1; upd_data = latch_q | op_operand; end
                OP_XOR:  begin upd_mask = ALL_1; upd_data = latch_q ^ op_operand; end
                OP_INC:  begin upd_mask = ALL_1; upd_data = latch_q + ONE; end
                OP_DEC:  begin
                    upd_mask = ALL_1;
                    upd_data = latch_q - ONE;
                    op_flag  = (latch_q != ONE);
                end
                OP_SETB: begin upd_mask = sel_mask; upd_data = latch_q | sel_mask; end
                OP_CLRB: begin upd_mask = sel_mask; upd_data = latch_q & ~sel_mask; end
                OP_CPLB: begin upd_mask = sel_mask; upd_data = latch_q ^ sel_mask; end
                OP_TCLR: begin
                    upd_mask = sel_mask;
                    upd_data = latch_q & ~sel_mask;
                    op_flag  = |(latch_q & sel_mask);
                end
                default: begin upd_mask = '0; upd_data = latch_q; end
            endcase
        end
    end

    // Bit operations must touch exactly one stored bit.
    always_comb begin
        if (rst_n && op_en && (code == OP_SETB || code == OP_CLRB ||
                               code == OP_CPLB || code == OP_TCLR)) begin
            AST_BITOP_ONE_BIT: assert ($countones(upd_mask) == 1); // R7
        end
    end

endmodule

// File: rtl/qbd_port_latch_bank.sv
// Module: per-bit storage flops of the port.
// Each bit loads its data input only when its mask bit is set, so bits are
// independent. Synchronous active-low reset loads all ones (pads released).
module qbd_port_latch_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_mask,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] latch_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Store one bit when its mask bit is set; reset to 1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                latch_q[i] <= 1'b1;
            else if (load_mask[i])
                latch_q[i] <= load_data[i];
        end
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mask == '0) |=> $stable(latch_q)); // R2

endmodule

// File: rtl/qbd_port_pad.sv
// Module: pad-side model of the port.
// A stored 0 pulls the pad low; a stored 1 releases it, with an internal
// pull-up only when HAS_PULLUP is 1. The pad read value is forced low for
// bits that drive low. Assumes pad_in is the level sensed at the pad.
module qbd_port_pad #(
    parameter int W          = 8,
    parameter bit HAS_PULLUP = 1'b1
) (
    input  logic         rst_n,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_drive_low,
    output logic [W-1:0] pad_pullup_en,
    output logic [W-1:0] rd_pin
);

    for (genvar i = 0; i < W; i++) begin : g_pad
        // Drive the pad low from a stored 0 and gate the sensed level.
        always_comb begin
            pad_drive_low[i] = ~latch_q[i];
            rd_pin[i]        = latch_q[i] & pad_in[i];
        end
        if (HAS_PULLUP) begin : g_pu
            // Enable the internal pull-up only while the pad is released.
            always_comb pad_pullup_en[i] = latch_q[i];
        end else begin : g_od
            // Open-drain build: no internal pull-up at all.
            always_comb pad_pullup_en[i] = 1'b0;
        end
    end

    // A driven-low pad never reads high and never has its pull-up enabled.
    always_comb begin
        if (rst_n) begin
            AST_LOW_PAD_READS_LOW: assert ((rd_pin & pad_drive_low) == '0);          // R3
            AST_NO_PULLUP_WHEN_LOW: assert ((pad_pullup_en & pad_drive_low) == '0);  // R4
        end
    end

endmodule

// File: rtl/qbd_port.sv
// Module: quasi-bidirectional parallel port, top level.
// Merges whole-byte writes and read-modify-write updates into the storage
// flops (operation wins over write), and exposes the pad and stored read
// paths. Assumes all inputs are synchronous to clk.
module qbd_port
    import qbd_port_pkg::*;
#(
    parameter int W          = 8,
    parameter bit HAS_PULLUP = 1'b1,
    localparam int IDXW      = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_data,
    input  logic            op_en,
    input  logic [OP_W-1:0] op_code,
    input  logic [W-1:0]    op_operand,
    input  logic [IDXW-1:0] bit_sel,
    input  logic [W-1:0]    pad_in,
    output logic [W-1:0]    rd_pin,
    output logic [W-1:0]    rd_latch,
    output logic            pin_bit,
    output logic            op_flag,
    output logic [W-1:0]    pad_drive_low,
    output logic [W-1:0]    pad_pullup_en
);

    logic [W-1:0] latch_q;
    logic [W-1:0] upd_mask;
    logic [W-1:0] upd_data;
    logic [W-1:0] load_mask;
    logic [W-1:0] load_data;

    qbd_port_alu #(.W(W), .IDXW(IDXW)) u_alu (
        .rst_n      (rst_n),
        .op_en      (op_en),
        .op_code    (op_code),
        .latch_q    (latch_q),
        .op_operand (op_operand),
        .bit_sel    (bit_sel),
        .upd_mask   (upd_mask),
        .upd_data   (upd_data),
        .op_flag    (op_flag)
    );

    // Choose the update source: any operation blocks the plain write.
    always_comb begin
        if (op_en) begin
            load_mask = upd_mask;
            load_data = upd_data;
        end else begin
            load_mask = {W{wr_en}};
            load_data = wr_data;
        end
    end

    qbd_port_latch_bank #(.W(W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_mask (load_mask),
        .load_data (load_data),
        .latch_q   (latch_q)
    );

    qbd_port_pad #(.W(W), .HAS_PULLUP(HAS_PULLUP)) u_pad (
        .rst_n         (rst_n),
        .latch_q       (latch_q),
        .pad_in        (pad_in),
        .pad_drive_low (pad_drive_low),
        .pad_pullup_en (pad_pullup_en),
        .rd_pin        (rd_pin)
    );

    // Expose the stored byte and the selected pad bit.
    always_comb begin
        rd_latch = latch_q;
        pin_bit  = rd_pin[bit_sel];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !op_en) |=> (rd_latch == $past(wr_data))); // R2

    AST_OP_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && wr_en && op_code == OP_AND)
        |=> (rd_latch == ($past(rd_latch) & $past(op_operand)))); // R9

    AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == OP_INC && rd_latch == {W{1'b1}})
        |=> (rd_latch == '0)); // R6

endmodule

// File: tb/tb_qbd_port.sv
`timescale 1ns/100ps
module tb_qbd_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       op_en = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] op_operand = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] rd_pin, rd_latch, pad_drive_low, pad_pullup_en;
    logic       pin_bit, op_flag;
    logic [7:0] od_pin, od_latch, od_drive_low, od_pullup_en;
    logic       od_pin_bit, od_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    qbd_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_en(op_en), .op_code(op_code), .op_operand(op_operand),
        .bit_sel(bit_sel), .pad_in(pad_in), .rd_pin(rd_pin),
        .rd_latch(rd_latch), .pin_bit(pin_bit), .op_flag(op_flag),
        .pad_drive_low(pad_drive_low), .pad_pullup_en(pad_pullup_en)
    );

    qbd_port #(.HAS_PULLUP(1'b0)) dut_od (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_en(op_en), .op_code(op_code), .op_operand(op_operand),
        .bit_sel(bit_sel), .pad_in(pad_in), .rd_pin(od_pin),
        .rd_latch(od_latch), .pin_bit(od_pin_bit), .op_flag(od_flag),
        .pad_drive_low(od_drive_low), .pad_pullup_en(od_pullup_en)
    );

    // {wr_en, wr_data, op_en, op_code, operand, bit_sel, exp_latch, exp_flag}
    localparam int NV = 16;
    localparam logic [33:0] VECS [NV] = '{
        {1'b1, 8'h55, 1'b0, 4'd0, 8'h00, 3'd0, 8'h55, 1'b0},  // R2 write
        {1'b0, 8'h00, 1'b1, 4'd2, 8'hFF, 3'd0, 8'hAA, 1'b0},  // R5 xor
        {1'b0, 8'h00, 1'b1, 4'd2, 8'hFF, 3'd0, 8'h55, 1'b0},  // R5 xor
        {1'b0, 8'h00, 1'b1, 4'd0, 8'h0F, 3'd0, 8'h05, 1'b0},  // R5 and
        {1'b0, 8'h00, 1'b1, 4'd1, 8'h30, 3'd0, 8'h35, 1'b0},  // R5 or
        {1'b0, 8'h00, 1'b1, 4'd3, 8'h00, 3'd0, 8'h36, 1'b0},  // R6 inc
        {1'b0, 8'h00, 1'b1, 4'd4, 8'h00, 3'd0, 8'h35, 1'b1},  // R6 dec
        {1'b0, 8'h00, 1'b1, 4'd5, 8'h00, 3'd7, 8'hB5, 1'b0},  // R7 set
        {1'b0, 8'h00, 1'b1, 4'd6, 8'h00, 3'd0, 8'hB4, 1'b0},  // R7 clear
        {1'b0, 8'h00, 1'b1, 4'd7, 8'h00, 3'd3, 8'hBC, 1'b0},  // R7 complement
        {1'b1, 8'h00, 1'b0, 4'd0, 8'h00, 3'd0, 8'h00, 1'b0},  // R2 write
        {1'b0, 8'h00, 1'b1, 4'd4, 8'h00, 3'd0, 8'hFF, 1'b1},  // R6 dec wrap
        {1'b0, 8'h00, 1'b1, 4'd3, 8'h00, 3'd0, 8'h00, 1'b0},  // R6 inc wrap
        {1'b1, 8'h12, 1'b1, 4'd1, 8'h0F, 3'd0, 8'h0F, 1'b0},  // R9 op beats write
        {1'b1, 8'hEE, 1'b1, 4'd9, 8'hFF, 3'd0, 8'h0F, 1'b0},  // R10 reserved code
        {1'b0, 8'hC3, 1'b0, 4'd0, 8'hFF, 3'd0, 8'h0F, 1'b0}   // R2 hold
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one update at a negedge, check the flag, then the stored byte.
    task automatic apply(input logic we, input logic [7:0] wd, input logic oe,
                         input logic [3:0] oc, input logic [7:0] opnd,
                         input logic [2:0] bs, input string req,
                         input logic [7:0] exp_latch, input logic exp_flag);
        wr_en = we; wr_data = wd; op_en = oe; op_code = oc;
        op_operand = opnd; bit_sel = bs;
        #1;
        check({req, " flag"}, {7'd0, op_flag}, {7'd0, exp_flag});
        @(negedge clk);
        wr_en = 1'b0; op_en = 1'b0;
        check({req, " latch"}, rd_latch, exp_latch);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 latch", rd_latch, 8'hFF);
        check("R1 drive_low", pad_drive_low, 8'h00);
        check("R1 pullup", pad_pullup_en, 8'hFF);
        check("R4 open-drain pullup", od_pullup_en, 8'h00);

        // R3 pad read against stored byte
        pad_in = 8'hA5; #1;
        check("R3 pin", rd_pin, 8'hA5);
        check("R3 latch unaffected", rd_latch, 8'hFF);
        bit_sel = 3'd1; #1;
        check("R11 pin_bit", {7'd0, pin_bit}, 8'h00);
        bit_sel = 3'd2; #1;
        check("R11 pin_bit", {7'd0, pin_bit}, 8'h01);

        // Table walk with quiet pads (operations read the stored byte)
        pad_in = 8'h00;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][33], VECS[i][32:25], VECS[i][24], VECS[i][23:20],
                  VECS[i][19:12], VECS[i][11:9], $sformatf("vec%0d", i),
                  VECS[i][8:1], VECS[i][0]);
        end

        // R4 pad controls follow 0x0F
        check("R4 drive_low", pad_drive_low, 8'hF0);
        check("R4 pullup", pad_pullup_en, 8'h0F);
        check("R4 open-drain pullup", od_pullup_en, 8'h00);
        pad_in = 8'hFF; #1;
        check("R3 driven-low pins read low", rd_pin, 8'h0F);
        pad_in = 8'h0D; #1;
        check("R3 pulled-low bit", rd_pin, 8'h0D);
        check("R3 latch keeps 1", rd_latch, 8'h0F);

        // R8 test-and-clear
        @(negedge clk);
        apply(1'b0, 8'h00, 1'b1, 4'd8, 8'h00, 3'd1, "R8 first", 8'h0D, 1'b1);
        apply(1'b0, 8'h00, 1'b1, 4'd8, 8'h00, 3'd1, "R8 second", 8'h0D, 1'b0);
        // R10 reserved code alone
        apply(1'b0, 8'h00, 1'b1, 4'd15, 8'h00, 3'd0, "R10 code15", 8'h0D, 1'b0);
        // R6 dec to zero gives flag 0
        apply(1'b1, 8'h01, 1'b0, 4'd0, 8'h00, 3'd0, "R2 write01", 8'h01, 1'b0);
        apply(1'b0, 8'h00, 1'b1, 4'd4, 8'h00, 3'd0, "R6 dec to zero", 8'h00, 1'b0);
        check("R4 drive_low all", pad_drive_low, 8'hFF);

        // R1 reset again restores all ones
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 re-reset", rd_latch, 8'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule